// File: doc/BRIEF.md
# Fly-by DMA Transfer Controller

This block is a single-channel direct memory access engine for a byte-wide host bus. When an I/O device raises its request, the controller asks the host processor for the bus. Once the processor grants it, the controller drives the memory address and a pair of command strobes for each transfer. In every transfer one strobe goes to the device and the opposite one goes to memory, so the data byte moves straight from one to the other. It never enters the controller, and the controller has no data input at all.

The low byte of the address leaves on dedicated pins. The high byte is placed on the shared data pins for one latch cycle, with a strobe that an external latch uses to capture it. That latch cycle opens every bus grant and is repeated only when the low byte wraps. An address-enable output marks the cycles in which the controller owns the bus, so system logic can keep the processor's drivers off it.

The processor programs the start address, the count, the direction and the mode through a small register port. It can do so only while it holds the bus itself. A count of N moves N+1 bytes. In block mode one request runs the whole count. In demand mode the bus is handed back after any transfer that ends while the request is low.

Top module: `flyby_dma`

## Requirements
- R1: With the channel enabled, `dreq` high and `hlda` low at a clock edge in the idle state, `hrq` is high from that edge on. With the channel disabled, `dreq` never raises `hrq`.
- R2: `aen`, `adstb`, `dack` and all four command strobes stay low until `hlda` has been seen high at a clock edge while `hrq` is high. The first bus-owning cycle of every grant is an address-latch cycle.
- R3: With the direction bit at 0 (device to memory), each transfer cycle asserts `io_rd`, `mem_wr` and `dack` together, and `mem_rd` and `io_wr` stay low.
- R4: With the direction bit at 1 (memory to device), each transfer cycle asserts `mem_rd`, `io_wr` and `dack` together, and `io_rd` and `mem_wr` stay low.
- R5: In an address-latch cycle, `adstb` and `db_oe` are high and `db_out` carries address bits 15:8. A latch cycle occurs at the start of each grant and, within a grant, only before the first transfer after the low address byte wraps from FF to 00. Whenever `aen` is high, `a_lo` carries address bits 7:0. When they are not being driven, `db_out` and `a_lo` are 0.
- R6: After each transfer the 16-bit address rises by one and the 16-bit count falls by one, wrapping. A loaded count of N yields N+1 transfers.
- R7: `eop` is high during the transfer in which the count is 0. After that transfer the enable bit reads back 0 and `hrq` is low in the next cycle.
- R8: In block mode (control bit 2 = 0) transfers continue without regard to `dreq` until the count is used up. In demand mode (bit 2 = 1) the controller returns to idle after a transfer that ends with `dreq` low, keeps its address, count and enable, and resumes with a new grant when `dreq` returns.
- R9: Register map (`haddr`): 0 = address bits 7:0, 1 = address bits 15:8, 2 = count bits 7:0, 3 = count bits 15:8, 4 = control (bit 0 enable, bit 1 direction, bit 2 demand mode). A write is `hsel` and `hwr` high at a clock edge and is ignored while `hlda` is high. `hrdata` shows the selected register while `hsel` is high, reads 0 for unmapped offsets, and reads 0 when `hsel` is low.
- R10: After reset, all outputs are low and the address, count and control registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsel | input | 1 | Register port select |
| hwr | input | 1 | Register write (with hsel) |
| haddr | input | 3 | Register offset |
| hwdata | input | 8 | Register write data |
| hrdata | output | 8 | Register read data |
| dreq | input | 1 | Device transfer request |
| dack | output | 1 | Device acknowledge, high in transfer cycles |
| hrq | output | 1 | Bus hold request to the processor |
| hlda | input | 1 | Bus hold acknowledge from the processor |
| aen | output | 1 | Controller owns the bus |
| adstb | output | 1 | Upper address byte latch strobe |
| a_lo | output | 8 | Address bits 7:0 |
| db_out | output | 8 | Address bits 15:8 on the shared data pins |
| db_oe | output | 1 | Drive enable for db_out |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| eop | output | 1 | End of process, high during the final transfer |

## Verification
The assertions check on every cycle the properties that depend only on nearby cycles. Bus ownership only with acknowledge, strobes paired by direction and tied to `dack`, a latch cycle opening each grant, `a_lo` stepping by one between adjacent transfers, and `hrq` falling right after `eop`. Transfer totals, the final address and count, mode-dependent release and resumption, and the ignoring of register writes during a grant can only be shown by the bench's scenarios. There, a behavioural model is compared with every output on every clock.

// File: rtl/flyby_dma_pkg.sv
package flyby_dma_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ASK   = 2'd1,
    PH_LATCH = 2'd2,
    PH_MOVE  = 2'd3
  } phase_e;

  localparam logic [2:0] REG_ADR_LO = 3'd0;
  localparam logic [2:0] REG_ADR_HI = 3'd1;
  localparam logic [2:0] REG_CNT_LO = 3'd2;
  localparam logic [2:0] REG_CNT_HI = 3'd3;
  localparam logic [2:0] REG_CTRL   = 3'd4;

  localparam int CTRL_EN  = 0;
  localparam int CTRL_DIR = 1;
  localparam int CTRL_DEM = 2;

endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= {sh_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = sh_q[STAGES-1];

endmodule

// File: rtl/dma_regs.sv
module dma_regs
  import flyby_dma_pkg::*;
#(
  parameter int DB_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hsel,
  input  logic            hwr,
  input  logic [2:0]      haddr,
  input  logic [DB_W-1:0] hwdata,
  input  logic            hlda,
  input  logic            step,
  input  logic            last,
  output logic [2*DB_W-1:0] addr_o,
  output logic [2*DB_W-1:0] cnt_o,
  output logic            en_o,
  output logic            dir_o,
  output logic            dem_o,
  output logic [DB_W-1:0] hrdata
);

  localparam int W = 2 * DB_W;

  logic [W-1:0] addr_q, addr_d;
  logic [W-1:0] cnt_q, cnt_d;
  logic         en_q, en_d;
  logic         dir_q, dir_d;
  logic         dem_q, dem_d;
  logic         wr_ok;
  logic         upd;

  assign wr_ok = hsel & hwr & ~hlda;
  assign upd   = step | wr_ok;

  always_comb begin
    addr_d = addr_q;
    cnt_d  = cnt_q;
    en_d   = en_q;
    dir_d  = dir_q;
    dem_d  = dem_q;
    if (step) begin
      addr_d = addr_q + W'(1);
      cnt_d  = cnt_q - W'(1);
      if (last) en_d = 1'b0;
    end else if (wr_ok) begin
      case (haddr)
        REG_ADR_LO: addr_d[DB_W-1:0] = hwdata;
        REG_ADR_HI: addr_d[W-1:DB_W] = hwdata;
        REG_CNT_LO: cnt_d[DB_W-1:0]  = hwdata;
        REG_CNT_HI: cnt_d[W-1:DB_W]  = hwdata;
        REG_CTRL: begin
          en_d  = hwdata[CTRL_EN];
          dir_d = hwdata[CTRL_DIR];
          dem_d = hwdata[CTRL_DEM];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      en_q   <= 1'b0;
      dir_q  <= 1'b0;
      dem_q  <= 1'b0;
    end else if (upd) begin
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
      en_q   <= en_d;
      dir_q  <= dir_d;
      dem_q  <= dem_d;
    end
  end

  always_comb begin
    hrdata = '0;
    if (hsel) begin
      case (haddr)
        REG_ADR_LO: hrdata = addr_q[DB_W-1:0];
        REG_ADR_HI: hrdata = addr_q[W-1:DB_W];
        REG_CNT_LO: hrdata = cnt_q[DB_W-1:0];
        REG_CNT_HI: hrdata = cnt_q[W-1:DB_W];
        REG_CTRL: begin
          hrdata[CTRL_EN]  = en_q;
          hrdata[CTRL_DIR] = dir_q;
          hrdata[CTRL_DEM] = dem_q;
        end
        default: hrdata = '0;
      endcase
    end
  end

  assign addr_o = addr_q;
  assign cnt_o  = cnt_q;
  assign en_o   = en_q;
  assign dir_o  = dir_q;
  assign dem_o  = dem_q;

endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import flyby_dma_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en,
  input  logic   dem,
  input  logic   dreq,
  input  logic   hlda,
  input  logic   cnt_zero,
  input  logic   lo_full,
  output phase_e ph_o,
  output logic   step,
  output logic   last
);

  phase_e ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    case (ph_q)
      PH_IDLE:  if (en && dreq && !hlda) ph_d = PH_ASK;
      PH_ASK: begin
        if (!en)       ph_d = PH_IDLE;
        else if (hlda) ph_d = PH_LATCH;
      end
      PH_LATCH: ph_d = PH_MOVE;
      PH_MOVE: begin
        if (cnt_zero)          ph_d = PH_IDLE;
        else if (dem && !dreq) ph_d = PH_IDLE;
        else if (lo_full)      ph_d = PH_LATCH;
        else                   ph_d = PH_MOVE;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
    end else begin
      ph_q <= ph_d;
    end
  end

  assign step = (ph_q == PH_MOVE);
  assign last = step & cnt_zero;
  assign ph_o = ph_q;

endmodule

// File: rtl/dma_bus.sv
module dma_bus
  import flyby_dma_pkg::*;
#(
  parameter int DB_W = 8
) (
  input  phase_e            ph,
  input  logic              dir,
  input  logic              last,
  input  logic [2*DB_W-1:0] addr,
  output logic              hrq,
  output logic              aen,
  output logic              adstb,
  output logic              db_oe,
  output logic [DB_W-1:0]   db_out,
  output logic [DB_W-1:0]   a_lo,
  output logic              dack,
  output logic              io_rd,
  output logic              io_wr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              eop
);

  localparam int W = 2 * DB_W;

  always_comb begin
    hrq    = (ph != PH_IDLE);
    aen    = (ph == PH_LATCH) || (ph == PH_MOVE);
    adstb  = (ph == PH_LATCH);
    db_oe  = adstb;
    db_out = adstb ? addr[W-1:DB_W] : '0;
    a_lo   = aen ? addr[DB_W-1:0] : '0;
    dack   = (ph == PH_MOVE);
    io_rd  = dack & ~dir;
    mem_wr = dack & ~dir;
    mem_rd = dack & dir;
    io_wr  = dack & dir;
    eop    = dack & last;
  end

endmodule

// File: rtl/flyby_dma.sv
module flyby_dma
  import flyby_dma_pkg::*;
#(
  parameter int DB_W      = 8,
  parameter int RST_STAGE = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hsel,
  input  logic            hwr,
  input  logic [2:0]      haddr,
  input  logic [DB_W-1:0] hwdata,
  output logic [DB_W-1:0] hrdata,
  input  logic            dreq,
  output logic            dack,
  output logic            hrq,
  input  logic            hlda,
  output logic            aen,
  output logic            adstb,
  output logic [DB_W-1:0] a_lo,
  output logic [DB_W-1:0] db_out,
  output logic            db_oe,
  output logic            io_rd,
  output logic            io_wr,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            eop
);

  localparam int W = 2 * DB_W;

  logic         srst_n;
  logic [W-1:0] addr, cnt;
  logic         en, dir, dem;
  logic         step, last;
  logic         cnt_zero, lo_full;
  phase_e       ph;

  assign cnt_zero = (cnt == '0);
  assign lo_full  = &addr[DB_W-1:0];

  dma_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  dma_regs #(.DB_W(DB_W)) u_regs (
    .clk    (clk),
    .rst_n  (srst_n),
    .hsel   (hsel),
    .hwr    (hwr),
    .haddr  (haddr),
    .hwdata (hwdata),
    .hlda   (hlda),
    .step   (step),
    .last   (last),
    .addr_o (addr),
    .cnt_o  (cnt),
    .en_o   (en),
    .dir_o  (dir),
    .dem_o  (dem),
    .hrdata (hrdata)
  );

  dma_seq u_seq (
    .clk      (clk),
    .rst_n    (srst_n),
    .en       (en),
    .dem      (dem),
    .dreq     (dreq),
    .hlda     (hlda),
    .cnt_zero (cnt_zero),
    .lo_full  (lo_full),
    .ph_o     (ph),
    .step     (step),
    .last     (last)
  );

  dma_bus #(.DB_W(DB_W)) u_bus (
    .ph     (ph),
    .dir    (dir),
    .last   (last),
    .addr   (addr),
    .hrq    (hrq),
    .aen    (aen),
    .adstb  (adstb),
    .db_oe  (db_oe),
    .db_out (db_out),
    .a_lo   (a_lo),
    .dack   (dack),
    .io_rd  (io_rd),
    .io_wr  (io_wr),
    .mem_rd (mem_rd),
    .mem_wr (mem_wr),
    .eop    (eop)
  );

endmodule

// File: rtl/flyby_dma_chk.sv
module flyby_dma_chk #(
  parameter int DB_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            hlda,
  input logic            hrq,
  input logic            aen,
  input logic            adstb,
  input logic            db_oe,
  input logic [DB_W-1:0] a_lo,
  input logic            dack,
  input logic            io_rd,
  input logic            io_wr,
  input logic            mem_rd,
  input logic            mem_wr,
  input logic            eop
);

  // R1
  req_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hrq) |-> !$past(hlda));

  // R2
  own_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aen |-> (hlda && hrq));

  // R2
  grant_opens_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aen) |-> adstb);

  // R3
  dev_to_mem_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd || mem_wr) |-> (io_rd && mem_wr && dack && !mem_rd && !io_wr));

  // R4
  mem_to_dev_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || io_wr) |-> (mem_rd && io_wr && dack && !io_rd && !mem_wr));

  // R3
  dack_has_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dack |-> ($countones({io_rd, mem_rd}) == 1));

  // R5
  latch_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adstb |-> (db_oe && aen && !dack));

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dack |=> (!aen || (a_lo == ($past(a_lo) + DB_W'(1)))));

  // R7
  eop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eop |=> !hrq);

  // R7
  eop_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eop |-> dack);

endmodule

bind flyby_dma flyby_dma_chk #(.DB_W(DB_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .hlda   (hlda),
  .hrq    (hrq),
  .aen    (aen),
  .adstb  (adstb),
  .db_oe  (db_oe),
  .a_lo   (a_lo),
  .dack   (dack),
  .io_rd  (io_rd),
  .io_wr  (io_wr),
  .mem_rd (mem_rd),
  .mem_wr (mem_wr),
  .eop    (eop)
);

// File: tb/flyby_dma_test.sv
module flyby_dma_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hsel = 1'b0, hwr = 1'b0;
  logic [2:0] haddr = '0;
  logic [7:0] hwdata = '0;
  logic [7:0] hrdata;
  logic       dreq = 1'b0, hlda = 1'b0;
  logic       dack, hrq, aen, adstb, db_oe, io_rd, io_wr, mem_rd, mem_wr, eop;
  logic [7:0] a_lo, db_out;

  int nchk = 0, nerr = 0;
  int ack_delay = 2, wait_cnt = 0;
  int n_iord = 0, n_iowr = 0, n_memrd = 0, n_memwr = 0, n_adstb = 0, n_eop = 0, n_hrq = 0;
  logic [7:0] latched[$];

  // behavioural model state
  int         mph = 0;
  logic [15:0] maddr = '0, mcnt = '0;
  bit         men = 0, mdir = 0, mdem = 0;

  always #4 clk = ~clk;

  flyby_dma uut (
    .clk(clk), .rst_n(rst_n), .hsel(hsel), .hwr(hwr), .haddr(haddr), .hwdata(hwdata),
    .hrdata(hrdata), .dreq(dreq), .dack(dack), .hrq(hrq), .hlda(hlda), .aen(aen),
    .adstb(adstb), .a_lo(a_lo), .db_out(db_out), .db_oe(db_oe), .io_rd(io_rd),
    .io_wr(io_wr), .mem_rd(mem_rd), .mem_wr(mem_wr), .eop(eop)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cmp(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    chk(act === exp, req, what, act, exp);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  endtask

  // model update, inputs are stable here (driven at posedge + 2)
  always @(posedge clk) begin
    if (!rst_n) begin
      mph = 0; maddr = '0; mcnt = '0; men = 0; mdir = 0; mdem = 0;
    end else if (mph == 3) begin
      maddr = maddr + 16'd1;
      if (mcnt == 16'd0) begin
        men = 0; mph = 0;
      end else if (mdem && !dreq) begin
        mph = 0;
      end else if (maddr[7:0] == 8'h00) begin
        mph = 2;
      end
      mcnt = mcnt - 16'd1;
    end else begin
      bit wr;
      wr = hsel && hwr && !hlda;
      if (mph == 2) mph = 3;
      else if (mph == 1) begin
        if (!men) mph = 0;
        else if (hlda) mph = 2;
      end else if (men && dreq && !hlda) mph = 1;
      if (wr) begin
        case (haddr)
          3'd0: maddr[7:0]  = hwdata;
          3'd1: maddr[15:8] = hwdata;
          3'd2: mcnt[7:0]   = hwdata;
          3'd3: mcnt[15:8]  = hwdata;
          3'd4: begin men = hwdata[0]; mdir = hwdata[1]; mdem = hwdata[2]; end
          default: ;
        endcase
      end
    end
  end

  // every-cycle comparison and event counting
  always @(negedge clk) begin
    if (rst_n) begin
      bit xf;
      logic [7:0] rd_exp;
      xf = (mph == 3);
      rd_exp = 8'h00;
      if (hsel) begin
        case (haddr)
          3'd0: rd_exp = maddr[7:0];
          3'd1: rd_exp = maddr[15:8];
          3'd2: rd_exp = mcnt[7:0];
          3'd3: rd_exp = mcnt[15:8];
          3'd4: rd_exp = {5'd0, mdem, mdir, men};
          default: rd_exp = 8'h00;
        endcase
      end
      cmp("R1", "hrq", hrq, mph != 0);
      cmp("R2", "aen", aen, mph >= 2);
      cmp("R3", "dack", dack, xf);
      cmp("R3", "io_rd/mem_wr", {io_rd, mem_wr}, {2{xf && !mdir}});
      cmp("R4", "mem_rd/io_wr", {mem_rd, io_wr}, {2{xf && mdir}});
      cmp("R5", "adstb/db_oe", {adstb, db_oe}, {2{mph == 2}});
      cmp("R5", "db_out", db_out, (mph == 2) ? maddr[15:8] : 8'h00);
      cmp("R5", "a_lo", a_lo, (mph >= 2) ? maddr[7:0] : 8'h00);
      cmp("R7", "eop", eop, xf && mcnt == 16'd0);
      cmp("R9", "hrdata", hrdata, rd_exp);
      if (io_rd) n_iord++;
      if (io_wr) n_iowr++;
      if (mem_rd) n_memrd++;
      if (mem_wr) n_memwr++;
      if (eop) n_eop++;
      if (hrq) n_hrq++;
      if (adstb) begin n_adstb++; latched.push_back(db_out); end
    end
  end

  // processor side: grants the bus ack_delay cycles after the request
  initial begin
    forever begin
      @(posedge clk); #2;
      if (!hrq) begin hlda = 1'b0; wait_cnt = 0; end
      else if (wait_cnt >= ack_delay) hlda = 1'b1;
      else wait_cnt++;
    end
  end

  task automatic host_wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    hsel = 1'b1; hwr = 1'b1; haddr = a; hwdata = d;
    @(posedge clk); #2;
    hsel = 1'b0; hwr = 1'b0;
  endtask

  task automatic host_rd(input logic [2:0] a, output logic [7:0] d);
    @(posedge clk); #2;
    hsel = 1'b1; hwr = 1'b0; haddr = a;
    @(negedge clk); d = hrdata;
    @(posedge clk); #2;
    hsel = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!hrq && !hlda) break;
    end
  endtask

  task automatic clr_counts();
    n_iord = 0; n_iowr = 0; n_memrd = 0; n_memwr = 0; n_adstb = 0; n_eop = 0; n_hrq = 0;
    latched.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R10: reset state
    @(negedge clk);
    cmp("R10", "outputs after reset",
        {hrq, aen, adstb, db_oe, dack, io_rd, io_wr, mem_rd, mem_wr, eop}, 16'd0);
    host_rd(3'd4, r); cmp("R10", "control after reset", r, 8'h00);
    host_rd(3'd0, r); cmp("R10", "address after reset", r, 8'h00);
    host_rd(3'd2, r); cmp("R10", "count after reset", r, 8'h00);

    // R1: disabled channel ignores dreq
    clr_counts();
    @(posedge clk); #2 dreq = 1'b1;
    repeat (6) @(posedge clk);
    #2 dreq = 1'b0;
    @(negedge clk);
    cmp("R1", "hrq cycles while disabled", n_hrq, 0);

    // Block mode, device to memory, crossing a low-byte wrap
    ack_delay = 3;
    host_wr(3'd0, 8'hFE); host_wr(3'd1, 8'h12);
    host_wr(3'd2, 8'h03); host_wr(3'd3, 8'h00);
    host_wr(3'd4, 8'h01);
    clr_counts();
    @(posedge clk); #2 dreq = 1'b1;
    @(posedge clk); #2 dreq = 1'b0;
    wait_idle();
    cmp("R6", "io_rd transfers for count 3", n_iord, 4);
    cmp("R3", "mem_wr transfers", n_memwr, 4);
    cmp("R3", "memory-read strobes in device-to-memory", n_memrd + n_iowr, 0);
    cmp("R8", "block mode ran without dreq", n_iord, 4);
    cmp("R5", "latch cycles with wrap", n_adstb, 2);
    if (latched.size() == 2) begin
      cmp("R5", "first upper byte", latched[0], 8'h12);
      cmp("R5", "upper byte after wrap", latched[1], 8'h13);
    end else cmp("R5", "latched count", latched.size(), 2);
    cmp("R7", "eop pulses", n_eop, 1);
    host_rd(3'd4, r); cmp("R7", "enable cleared", r, 8'h00);
    host_rd(3'd0, r); cmp("R6", "final address low", r, 8'h02);
    host_rd(3'd1, r); cmp("R6", "final address high", r, 8'h13);
    host_rd(3'd2, r); cmp("R6", "count low rolled", r, 8'hFF);
    host_rd(3'd3, r); cmp("R6", "count high rolled", r, 8'hFF);

    // Demand mode, memory to device, with release and resume
    ack_delay = 1;
    host_wr(3'd0, 8'h40); host_wr(3'd1, 8'h00);
    host_wr(3'd2, 8'h09); host_wr(3'd3, 8'h00);
    host_wr(3'd4, 8'h07);
    clr_counts();
    @(posedge clk); #2 dreq = 1'b1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (n_iowr >= 3) break;
    end
    // R9: write while the bus is granted must be ignored
    host_wr(3'd0, 8'hAA);
    @(posedge clk); #2 dreq = 1'b0;
    wait_idle();
    cmp("R8", "demand mode stopped early", n_iowr < 10, 1'b1);
    cmp("R4", "mem_rd matches io_wr", n_memrd, n_iowr);
    host_rd(3'd4, r); cmp("R8", "enable kept after demand release", r, 8'h07);
    host_rd(3'd0, r); cmp("R9", "address low ignores granted write", r, 8'h40 + 8'(n_iowr));
    @(posedge clk); #2 dreq = 1'b1;
    @(negedge clk);
    wait_idle();
    #2 dreq = 1'b0;
    cmp("R4", "io_wr transfers total", n_iowr, 10);
    cmp("R4", "device-read strobes in memory-to-device", n_iord + n_memwr, 0);
    cmp("R5", "one latch per grant", n_adstb, 2);
    cmp("R7", "eop after resume", n_eop, 1);
    host_rd(3'd0, r); cmp("R6", "address low after demand run", r, 8'h4A);
    host_rd(3'd5, r); cmp("R9", "unmapped offset reads 0", r, 8'h00);

    repeat (3) @(posedge clk);
    finish_run();
  end

endmodule